// File: doc/BRIEF.md
# Token-Arbitrated Channel Readout Sequencer

This block moves converted results out of a multi-channel sample store onto a 12-bit data bus that several devices share. Ownership of the bus passes along a daisy chain. A device may drive the bus only while it holds the token. When it receives the token, it reads the full set of results for one channel from its store. It places them on the bus one word per read clock, in ascending cell order, and then hands the token to the next device in the chain.

A 5-bit channel select picks the channel. The value is captured when the token arrives. The store is outside this block and is reached through a plain combinational read port: the block presents a channel and a cell index, and the store returns the word for that cell. The block registers each word before it reaches the bus, so the bus carries clean data and reads as zero whenever the device does not own it.

A channel select that names no implemented channel makes the device hand the token on at once, without driving any data. A synchronous token clear returns the device to idle from any state.

Top module: `rdo_token_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a token arrives, `bus_valid`, `tok_out` and `bus_data` are all zero.
- R2: A burst starts on the clock edge where `tok_in` is first sampled high after being sampled low. Counting that edge as the first, the word for cell 0 is on the bus after the second edge.
- R3: A burst drives exactly 256 consecutive valid words. Word k is the store content at cell index k of the selected channel, for k = 0 to 255 in ascending order.
- R4: Whenever `bus_valid` is low, `bus_data` is all zeros.
- R5: On the edge after the one that ended the word for cell 255, `bus_valid` falls and `tok_out` goes high for exactly one clock. The device is then idle.
- R6: The channel is captured from `ch_sel` when the burst starts. Changing `ch_sel` during the burst does not change which channel is read.
- R7: A channel select of 5 or more (5 channels are implemented, numbered 0 to 4) makes `tok_out` pulse on the starting edge itself, and no word is driven.
- R8: `tok_clr`, sampled high on an edge, overrides everything. After that edge, `bus_valid` and `tok_out` are low and the burst is abandoned with no token pass. A `tok_in` rise sampled on the same edge is discarded. The next burst starts again at cell 0.
- R9: A new `tok_in` rise during a burst is ignored. The burst still delivers 256 words and one token pulse.
- R10: Holding `tok_in` high after a burst does not start another burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_in | input | 1 | Token from the previous device; a rise starts a burst |
| tok_clr | input | 1 | Synchronous token clear |
| ch_sel | input | 5 | Channel select, captured at burst start |
| mem_ch | output | 5 | Channel presented to the store read port |
| mem_idx | output | 8 | Cell index presented to the store read port |
| mem_data | input | 12 | Word returned by the store for `mem_ch`/`mem_idx` |
| bus_data | output | 12 | Shared data bus; zero when not owned |
| bus_valid | output | 1 | High on each cycle that carries a driven word |
| tok_out | output | 1 | One-clock token pulse to the next device |

## Verification
Bursts run on the lowest, the highest and a middle implemented channel, with a different content pattern per channel in the store. A word from the wrong channel or cell therefore shows up as a data mismatch, and the position of the first valid word and of the token pulse exposes an off-by-one in latency or burst length. Two patterns change inputs partway through a burst: one moves `ch_sel`, the other toggles `tok_in`. These show whether the channel is captured at the start and whether starts are locked out while a burst runs. Out-of-range selects just above the channel count and at the top of the address range test the immediate pass. Directed sequences then cover a `tok_in` held high, a clear in the middle of a burst, and a clear that arrives on the same edge as a token rise.

// File: rtl/rdo_pkg.sv
// Shared types for the token readout sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rdo_pkg;

    // Sequencer phases: waiting for a token, streaming words, handing the token on.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DONE  = 2'd2
    } rdo_state_e;

endpackage

// File: rtl/rdo_edge_detect.sv
// Rising-edge detector on a level input sampled by the read clock.
// Assumes din is already synchronous to clk.
module rdo_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic din_q;

    // Remember the previous sample of din.
    always_ff @(posedge clk) begin
        if (!rst_n) din_q <= 1'b0;
        else        din_q <= din;
    end

    assign rise = din & ~din_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R10

endmodule

// File: rtl/rdo_index_ctr.sv
// Cell index counter for one burst: loads zero, steps by one, wraps after the last cell.
// Assumes DEPTH is at least 2.
module rdo_index_ctr #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    assign last = (idx == LAST_IDX);

    // Advance, restart or clear the cell index.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) idx <= '0;
        else if (step)             idx <= last ? '0 : idx + 1'b1;
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && !load && !last) |=> (idx == $past(idx) + 1'b1)); // R3
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (idx == '0)); // R3

endmodule

// File: rtl/rdo_bus_reg.sv
// Output stage for the shared bus: captures a word when enabled, otherwise drives zeros.
// Assumes the store read port settles within one read clock.
module rdo_bus_reg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              vld
);

    // Register the word and its valid flag, releasing the bus to zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dout <= '0;
            vld  <= 1'b0;
        end else begin
            dout <= cap ? din : '0;
            vld  <= cap;
        end
    end

    AST_VLD_FOLLOWS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !clr) |=> vld); // R3

endmodule

// File: rtl/rdo_token_seq.sv
// Token-arbitrated readout sequencer. A rise on tok_in starts a burst that reads
// every cell of the captured channel through the store read port. Each word appears
// on the bus one clock after its index is presented. After the last word the token
// is passed on with a one-clock pulse. An unimplemented channel passes the token at once.
// Assumes the store read port is combinational and that all inputs are synchronous to clk.
module rdo_token_seq #(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 5,
    parameter int N_CH   = 5,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic              tok_clr,
    input  logic [ADDR_W-1:0] ch_sel,
    output logic [ADDR_W-1:0] mem_ch,
    output logic [IDX_W-1:0]  mem_idx,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_valid,
    output logic              tok_out
);

    import rdo_pkg::*;

    rdo_state_e        state;
    logic [ADDR_W-1:0] ch_q;
    logic              tok_out_q;
    logic              tok_rise;
    logic              ch_ok;
    logic              start;
    logic              idx_last;
    logic              streaming;

    rdo_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tok_in),
        .rise  (tok_rise)
    );

    // Check whether the select names an implemented channel.
    assign ch_ok     = ((ADDR_W + 1)'(ch_sel) < (ADDR_W + 1)'(N_CH));
    // Accept a token only when idle, not mid-pass, and not being cleared.
    assign start     = tok_rise && (state == ST_IDLE) && !tok_out_q && !tok_clr;
    assign streaming = (state == ST_BURST);

    // Phase sequencing, channel capture and token hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ch_q      <= '0;
            tok_out_q <= 1'b0;
        end else if (tok_clr) begin
            state     <= ST_IDLE;
            tok_out_q <= 1'b0;
        end else begin
            tok_out_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (ch_ok) begin
                            state <= ST_BURST;
                            ch_q  <= ch_sel;
                        end else begin
                            tok_out_q <= 1'b1;
                        end
                    end
                end
                ST_BURST: begin
                    if (idx_last) state <= ST_DONE;
                end
                ST_DONE: begin
                    state     <= ST_IDLE;
                    tok_out_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    rdo_index_ctr #(.DEPTH(DEPTH)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tok_clr),
        .load  (start),
        .step  (streaming),
        .idx   (mem_idx),
        .last  (idx_last)
    );

    rdo_bus_reg #(.DATA_W(DATA_W)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tok_clr),
        .cap   (streaming),
        .din   (mem_data),
        .dout  (bus_data),
        .vld   (bus_valid)
    );

    assign mem_ch  = ch_q;
    assign tok_out = tok_out_q;

    AST_TOK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out); // R5
    AST_TOK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> !bus_valid); // R5
    AST_BUS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (bus_data == '0)); // R4
    AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && !tok_clr) |=> $stable(mem_ch)); // R6
    AST_BAD_CH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ch_ok) |=> (tok_out && !bus_valid)); // R7
    AST_CLR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        tok_clr |=> (!bus_valid && !tok_out)); // R8

endmodule

// File: tb/rdo_token_seq_bench.sv
module rdo_token_seq_bench;

    localparam int DW = 12;
    localparam int AW = 5;
    localparam int NC = 5;
    localparam int DEPTH = 256;
    localparam int IW = 8;

    typedef struct packed {
        logic [AW-1:0] ch;
        logic          ok;
        logic          wig;
        logic [AW-1:0] alt;
    } vec_t;

    // Channel, expected-implemented flag (ch < 5), tok_in toggle mid-burst, ch_sel value applied mid-burst.
    localparam vec_t VECS [6] = '{
        '{5'd0,  1'b1, 1'b0, 5'd0},
        '{5'd3,  1'b1, 1'b1, 5'd3},
        '{5'd4,  1'b1, 1'b0, 5'd2},
        '{5'd5,  1'b0, 1'b0, 5'd0},
        '{5'd31, 1'b0, 1'b0, 5'd0},
        '{5'd2,  1'b1, 1'b1, 5'd6}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_in = 1'b0;
    logic tok_clr = 1'b0;
    logic [AW-1:0] ch_sel = '0;
    logic [AW-1:0] mem_ch;
    logic [IW-1:0] mem_idx;
    logic [DW-1:0] mem_data;
    logic [DW-1:0] bus_data;
    logic bus_valid;
    logic tok_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Store model: distinct content per channel and cell.
    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] ch, input logic [IW-1:0] idx);
        return 12'(ch * 613) ^ 12'(idx * 7) ^ 12'h5A5;
    endfunction

    assign mem_data = word_of(mem_ch, mem_idx);

    rdo_token_seq u_rdo_token_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_in    (tok_in),
        .tok_clr   (tok_clr),
        .ch_sel    (ch_sel),
        .mem_ch    (mem_ch),
        .mem_idx   (mem_idx),
        .mem_data  (mem_data),
        .bus_data  (bus_data),
        .bus_valid (bus_valid),
        .tok_out   (tok_out)
    );

    task automatic chk(input bit ok, input string msg, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called at a negedge: raise the token and observe 263 cycles after the start edge.
    task automatic do_burst(input logic [AW-1:0] ch, input bit ok, input bit wig, input logic [AW-1:0] alt);
        int nvalid = 0;
        int bad = 0;
        int zbad = 0;
        int ntok = 0;
        int tokat = -1;
        int firstv = -1;
        ch_sel = ch;
        tok_in = 1'b1;
        for (int c = 0; c <= 262; c++) begin
            @(negedge clk);
            if (bus_valid) begin
                nvalid++;
                if (firstv < 0) firstv = c;
                if (bus_data != word_of(ch, IW'(c - 1))) bad++;
            end else if (bus_data != '0) begin
                zbad++;
            end
            if (tok_out) begin
                ntok++;
                tokat = c;
            end
            if (c == 50) ch_sel = alt;
            if (wig && c == 100) tok_in = 1'b0;
            if (wig && c == 101) tok_in = 1'b1;
        end
        tok_in = 1'b0;
        chk(zbad == 0, "R4 bus zero while not valid", zbad, 0);
        if (ok) begin
            chk(firstv == 1, "R2 first word position", firstv, 1);
            chk(nvalid == 256, "R3 R9 burst word count", nvalid, 256);
            chk(bad == 0, "R3 R6 word content mismatches", bad, 0);
            chk(ntok == 1 && tokat == 257, "R5 token pulse position", tokat, 257);
        end else begin
            chk(nvalid == 0, "R7 no data for unimplemented channel", nvalid, 0);
            chk(ntok == 1 && tokat == 0, "R7 immediate token pass", tokat, 0);
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int nv;
        int nt;
        repeat (3) @(negedge clk);
        chk(!bus_valid && !tok_out && bus_data == '0, "R1 outputs in reset",
            int'({bus_valid, tok_out, bus_data}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!bus_valid && !tok_out && bus_data == '0, "R1 outputs idle after reset",
            int'({bus_valid, tok_out, bus_data}), 0);

        // Table-driven bursts.
        foreach (VECS[i]) begin
            do_burst(VECS[i].ch, VECS[i].ok, VECS[i].wig, VECS[i].alt);
        end

        // R10: tok_in held high for two burst lengths yields one burst only.
        nv = 0;
        nt = 0;
        ch_sel = 5'd1;
        tok_in = 1'b1;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (bus_valid) nv++;
            if (tok_out) nt++;
        end
        chk(nv == 256, "R10 held token valid count", nv, 256);
        chk(nt == 1, "R10 held token pulse count", nt, 1);
        tok_in = 1'b0;
        repeat (3) @(negedge clk);

        // R8: clear in the middle of a burst.
        ch_sel = 5'd2;
        tok_in = 1'b1;
        repeat (41) @(negedge clk);
        chk(bus_valid == 1'b1, "R8 burst running before clear", int'(bus_valid), 1);
        tok_clr = 1'b1;
        @(negedge clk);
        tok_clr = 1'b0;
        chk(!bus_valid && !tok_out, "R8 abort after clear", int'({bus_valid, tok_out}), 0);
        nv = 0;
        nt = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (bus_valid) nv++;
            if (tok_out) nt++;
        end
        chk(nv == 0 && nt == 0, "R8 no activity after abort", nv + nt, 0);
        tok_in = 1'b0;
        repeat (3) @(negedge clk);

        // R8: restart after clear begins at cell 0.
        ch_sel = 5'd2;
        tok_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_valid && bus_data == word_of(5'd2, 8'd0), "R8 restart at cell 0",
            int'(bus_data), int'(word_of(5'd2, 8'd0)));
        repeat (270) @(negedge clk);
        tok_in = 1'b0;
        repeat (3) @(negedge clk);

        // R8: a clear on the same edge as the token rise discards the start.
        ch_sel = 5'd0;
        tok_in = 1'b1;
        tok_clr = 1'b1;
        @(negedge clk);
        tok_clr = 1'b0;
        nv = 0;
        nt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (bus_valid) nv++;
            if (tok_out) nt++;
        end
        chk(nv == 0 && nt == 0, "R8 clear beats simultaneous rise", nv + nt, 0);
        tok_in = 1'b0;
        repeat (3) @(negedge clk);

        finish_run();
    end

endmodule